// File: doc/BRIEF.md
# LCD Row-Scan Sequencer

This block produces the row-scan timing for a dot-matrix LCD panel with 34 common electrodes and 120 segment electrodes at 1/33 duty. The display time is cut into 33 common slots per frame. During every slot the block asks a pixel source for 120 bits, one per clock, and shifts them into a 120-bit register. At the end of the slot it copies that register in parallel into a 120-bit segment latch and moves the common drive to the matching row. The row being displayed and the row being fetched therefore overlap: the fetch for slot k+1 runs while slot k is on the glass.

Slot 0 is the icon slot. It drives the two outer commons (index 0 and index 33) together, and the pixel source is told through a flag that icon memory is being read. Slots 1 to 32 are character dot rows, grouped into four text lines of eight dot rows each. For these slots the block reports the text line and the dot row within it, so a font or icon lookup can be placed in front of the serial pixel input. The slot length in clocks is set by an input. It is never shorter than the 120 clocks that a full shift needs.

Top module: `lcd_scan_seq`

## Requirements
- R1: While `rst` is high, `com_out` and `seg_out` are all zero and `frame_start` is low. The first cycle after reset requests column 0 of slot 0.
- R2: In slot cycles 0 to 119, `pix_req` is high and `pix_col` equals the cycle index within the slot. In any later cycle of the slot, `pix_req` is low.
- R3: `pix_row` gives the slot whose data is being fetched, in the range 0 to 32. `pix_icon` is 1 exactly when `pix_row` is 0. For rows 1 to 32, `pix_line` = (row-1)/8 and `pix_dot` = (row-1) mod 8. For row 0, both are 0.
- R4: The bit that `pix_bit` supplies while `pix_col` = c appears on `seg_out[c]` when the slot that was fetched becomes the displayed slot.
- R5: `seg_out` changes only in the cycle in which the common drive changes. It holds its value for the whole slot.
- R6: A slot lasts max(`slot_len`, 120) clocks. A value below 120, including 0, is treated as 120.
- R7: Displayed slot k in 1..32 drives only `com_out[k]`. Slot 0 drives `com_out[0]` and `com_out[33]` together, and no other pattern occurs.
- R8: Displayed slots follow the order 0, 1, ..., 32, then back to 0. A frame is 33 slots.
- R9: `frame_start` is high for exactly the first cycle in which slot 0 is displayed.
- R10: During the first slot after reset, nothing has been fetched yet. `com_out` and `seg_out` stay zero until the first slot boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| slot_len | input | 10 | Requested clocks per common slot (minimum 120 applied) |
| pix_req | output | 1 | Pixel bit requested this cycle |
| pix_row | output | 6 | Slot being fetched (0 = icon slot) |
| pix_col | output | 7 | Segment column being fetched |
| pix_icon | output | 1 | Fetch targets icon memory |
| pix_line | output | 3 | Text line of the fetched dot row |
| pix_dot | output | 3 | Dot row within the text line |
| pix_bit | input | 1 | Pixel value for the current request, valid in the same cycle |
| seg_out | output | 120 | Latched segment data for the displayed row |
| com_out | output | 34 | Common drive for the displayed row |
| frame_start | output | 1 | One-cycle pulse when slot 0 becomes displayed |

## Verification
The fetch outputs are combinational decodes of the slot counters. They are due in the same cycle as the counter state, and the pixel source answers within that cycle. The latched segment word, the common drive and the frame pulse move one clock edge after the last cycle of a slot, which is cycle max(`slot_len`,120)-1. A behavioural model in the bench advances its own slot counters on each rising edge and is compared with every output at the following falling edge, so each registered result is checked in the cycle it is due. Slot lengths and frame intervals are measured from the observed edges of `com_out` and `frame_start`. This is done only for slots in which `slot_len` did not change.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    localparam int unsigned COM_COUNT  = 34;
    localparam int unsigned SEG_COUNT  = 120;
    localparam int unsigned LEN_BITS   = 10;
    localparam int unsigned DOTS_LINE  = 8;
endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
    parameter int unsigned NUM_SEG  = 120,
    parameter int unsigned NUM_SLOT = 33,
    parameter int unsigned LEN_W    = 10,
    localparam int unsigned SLOT_W  = $clog2(NUM_SLOT),
    localparam int unsigned COL_W   = $clog2(NUM_SEG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  slot_len,
    output logic [COL_W-1:0]  col,
    output logic [SLOT_W-1:0] fill_slot,
    output logic              shifting,
    output logic              boundary
);
    localparam logic [LEN_W-1:0]  SEG_L     = LEN_W'(NUM_SEG);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOT - 1);

    typedef struct packed {
        logic [LEN_W-1:0]  cyc;
        logic [SLOT_W-1:0] fill;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [LEN_W-1:0] last_cyc;

    always_comb begin
        st_d     = st_q;
        last_cyc = (slot_len < SEG_L) ? SEG_L - 1'b1 : slot_len - 1'b1;
        shifting = st_q.cyc < SEG_L;
        boundary = st_q.cyc >= last_cyc;
        if (boundary) begin
            st_d.cyc  = '0;
            st_d.fill = (st_q.fill == LAST_SLOT) ? '0 : st_q.fill + 1'b1;
        end else begin
            st_d.cyc  = st_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign col       = st_q.cyc[COL_W-1:0];
    assign fill_slot = st_q.fill;
endmodule

// File: rtl/lcd_seg_pipe.sv
module lcd_seg_pipe #(
    parameter int unsigned NUM_SEG = 120
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               din,
    input  logic               load,
    output logic [NUM_SEG-1:0] seg
);
    typedef struct packed {
        logic [NUM_SEG-1:0] sh;
        logic [NUM_SEG-1:0] lat;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        // first column shifted in ends at bit 0 after NUM_SEG shifts
        if (shift_en) p_d.sh = {din, p_q.sh[NUM_SEG-1:1]};
        // take the post-shift value so a minimum-length slot still latches the last column
        if (load) p_d.lat = p_d.sh;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign seg = p_q.lat;
endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive #(
    parameter int unsigned NUM_COM = 34,
    localparam int unsigned NUM_SLOT = NUM_COM - 1,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [SLOT_W-1:0]  slot,
    output logic [NUM_COM-1:0] com,
    output logic               frame
);
    typedef struct packed {
        logic [NUM_COM-1:0] com;
        logic               frame;
    } cd_t;

    cd_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.frame = 1'b0;
        if (load) begin
            for (int k = 0; k < NUM_COM; k++) begin
                c_d.com[k] = (k < NUM_SLOT) && (SLOT_W'(k) == slot);
            end
            if (slot == '0) begin
                c_d.com[NUM_COM-1] = 1'b1;
                c_d.frame          = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign com   = c_q.com;
    assign frame = c_q.frame;
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter int unsigned NUM_COM = COM_COUNT,
    parameter int unsigned NUM_SEG = SEG_COUNT,
    parameter int unsigned LEN_W   = LEN_BITS,
    parameter int unsigned DOTS    = DOTS_LINE,
    localparam int unsigned NUM_SLOT = NUM_COM - 1,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOT),
    localparam int unsigned COL_W    = $clog2(NUM_SEG),
    localparam int unsigned DOT_W    = $clog2(DOTS),
    localparam int unsigned LINE_W   = SLOT_W - DOT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LEN_W-1:0]   slot_len,
    output logic               pix_req,
    output logic [SLOT_W-1:0]  pix_row,
    output logic [COL_W-1:0]   pix_col,
    output logic               pix_icon,
    output logic [LINE_W-1:0]  pix_line,
    output logic [DOT_W-1:0]   pix_dot,
    input  logic               pix_bit,
    output logic [NUM_SEG-1:0] seg_out,
    output logic [NUM_COM-1:0] com_out,
    output logic               frame_start
);
    logic              shifting;
    logic              boundary;
    logic [SLOT_W-1:0] fill_slot;
    logic [SLOT_W-1:0] row_m1;

    lcd_scan_timer #(.NUM_SEG(NUM_SEG), .NUM_SLOT(NUM_SLOT), .LEN_W(LEN_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .slot_len  (slot_len),
        .col       (pix_col),
        .fill_slot (fill_slot),
        .shifting  (shifting),
        .boundary  (boundary)
    );

    lcd_seg_pipe #(.NUM_SEG(NUM_SEG)) u_seg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shifting),
        .din      (pix_bit),
        .load     (boundary),
        .seg      (seg_out)
    );

    lcd_com_drive #(.NUM_COM(NUM_COM)) u_com (
        .clk   (clk),
        .rst   (rst),
        .load  (boundary),
        .slot  (fill_slot),
        .com   (com_out),
        .frame (frame_start)
    );

    always_comb begin
        pix_req  = shifting;
        pix_row  = fill_slot;
        pix_icon = (fill_slot == '0);
        row_m1   = pix_icon ? '0 : fill_slot - 1'b1;
        pix_line = row_m1[SLOT_W-1:DOT_W];
        pix_dot  = row_m1[DOT_W-1:0];
    end
endmodule

// File: rtl/lcd_scan_seq_chk.sv
module lcd_scan_seq_chk #(
    parameter int unsigned NUM_COM = 34,
    parameter int unsigned NUM_SEG = 120,
    localparam int unsigned NUM_SLOT = NUM_COM - 1,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOT),
    localparam int unsigned COL_W    = $clog2(NUM_SEG)
) (
    input logic               clk,
    input logic               rst,
    input logic               pix_req,
    input logic [SLOT_W-1:0]  pix_row,
    input logic [COL_W-1:0]   pix_col,
    input logic [NUM_SEG-1:0] seg_out,
    input logic [NUM_COM-1:0] com_out,
    input logic               frame_start
);
    AST_COM_PATTERN: assert property (@(posedge clk) disable iff (rst)
        $onehot0(com_out) || (com_out[0] && com_out[NUM_COM-1] && $countones(com_out) == 2)); // R7

    AST_SEG_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(seg_out) |-> !$stable(com_out)); // R5

    AST_FRAME_ICON: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (com_out[0] && com_out[NUM_COM-1])); // R9

    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R9

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
        pix_req |-> (pix_col < COL_W'(NUM_SEG))); // R2

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        pix_row < SLOT_W'(NUM_SLOT)); // R3

    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
        $rose(com_out[1]) |-> $past(com_out[0])); // R8
endmodule

bind lcd_scan_seq lcd_scan_seq_chk #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_req     (pix_req),
    .pix_row     (pix_row),
    .pix_col     (pix_col),
    .seg_out     (seg_out),
    .com_out     (com_out),
    .frame_start (frame_start)
);

// File: tb/test_lcd_scan_seq.sv
module test_lcd_scan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 34;
    localparam int NS = 120;
    localparam int NSLOT = 33;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [9:0]    slot_len = 10'd120;
    logic          pix_req, pix_icon, pix_bit, frame_start;
    logic [5:0]    pix_row;
    logic [6:0]    pix_col;
    logic [2:0]    pix_line, pix_dot;
    logic [NS-1:0] seg_out;
    logic [NC-1:0] com_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_scan_seq i_lcd_scan_seq (
        .clk(clk), .rst(rst), .slot_len(slot_len),
        .pix_req(pix_req), .pix_row(pix_row), .pix_col(pix_col),
        .pix_icon(pix_icon), .pix_line(pix_line), .pix_dot(pix_dot),
        .pix_bit(pix_bit), .seg_out(seg_out), .com_out(com_out),
        .frame_start(frame_start)
    );

    function automatic bit src_bit(int row, int col);
        return bit'(((row * 7 + col * 3) ^ (col >> 2) ^ (row >> 1)) & 1);
    endfunction

    always_comb pix_bit = src_bit(int'(pix_row), int'(pix_col));

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    // reference model state
    int m_cyc, m_fill;
    bit m_bits [NS];
    logic [NS-1:0] m_seg;
    logic [NC-1:0] m_com;
    bit m_frame;
    bit m_started;

    function automatic int eff_len(int len);
        return (len < NS) ? NS : len;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0; m_fill = 0; m_seg = '0; m_com = '0; m_frame = 0; m_started = 0;
        end else begin
            if (m_cyc < NS) m_bits[m_cyc] = src_bit(m_fill, m_cyc);
            if (m_cyc >= eff_len(int'(slot_len)) - 1) begin
                for (int i = 0; i < NS; i++) m_seg[i] = m_bits[i];
                m_com = '0;
                if (m_fill == 0) begin m_com[0] = 1'b1; m_com[NC-1] = 1'b1; end
                else m_com[m_fill] = 1'b1;
                m_frame   = (m_fill == 0);
                m_fill    = (m_fill + 1) % NSLOT;
                m_cyc     = 0;
                m_started = 1;
            end else begin
                m_cyc++;
                m_frame = 0;
            end
        end
    end

    // observation state for slot length and frame interval
    logic [NC-1:0] prev_com;
    logic [NS-1:0] prev_seg;
    int  run_len, run_slen, frame_gap, frame_slen;
    bit  run_ok, run_clean, frame_ok, frame_clean;

    always @(negedge clk) begin
        if (rst) begin
            check(com_out == '0 && seg_out == '0 && !frame_start, "R1 reset outputs",
                  {com_out, frame_start}, '0);
            prev_com = '0; prev_seg = '0; run_ok = 0; frame_ok = 0;
            run_len = 0; frame_gap = 0;
        end else if (!done) begin
            // registered outputs
            check(com_out == m_com, "R7 common drive", com_out, m_com);
            check(seg_out == m_seg, "R4 segment latch", seg_out, m_seg);
            check(frame_start == m_frame, "R9 frame pulse", frame_start, m_frame);
            if (!m_started)
                check(com_out == '0 && seg_out == '0, "R10 blank first slot", com_out, '0);
            // fetch side
            check(pix_req == (m_cyc < NS), "R2 request window", pix_req, m_cyc < NS);
            if (m_cyc < NS) check(int'(pix_col) == m_cyc, "R2 column", pix_col, m_cyc);
            check(int'(pix_row) == m_fill, "R3 fetch row", pix_row, m_fill);
            check(pix_icon == (m_fill == 0), "R3 icon flag", pix_icon, m_fill == 0);
            if (m_fill == 0)
                check(pix_line == 0 && pix_dot == 0, "R3 icon line/dot", {pix_line, pix_dot}, 0);
            else
                check(int'(pix_line) == (m_fill-1)/8 && int'(pix_dot) == (m_fill-1)%8,
                      "R3 line/dot", {pix_line, pix_dot}, (((m_fill-1)/8) << 3) | ((m_fill-1)%8));
            // segment stays put inside a slot
            check(!(seg_out != prev_seg && com_out == prev_com), "R5 segment hold", seg_out, prev_seg);
            // slot length
            if (com_out != prev_com) begin
                if (run_ok && run_clean)
                    check(run_len == eff_len(run_slen), "R6 slot length", run_len, eff_len(run_slen));
                run_ok = 1; run_len = 1; run_slen = int'(slot_len); run_clean = 1;
            end else begin
                run_len++;
            end
            if (int'(slot_len) != run_slen) run_clean = 0;
            // frame interval
            if (frame_start) begin
                if (frame_ok && frame_clean)
                    check(frame_gap == NSLOT * eff_len(frame_slen), "R8 frame interval",
                          frame_gap, NSLOT * eff_len(frame_slen));
                frame_ok = 1; frame_gap = 1; frame_slen = int'(slot_len); frame_clean = 1;
            end else begin
                frame_gap++;
            end
            if (int'(slot_len) != frame_slen) frame_clean = 0;
            prev_com = com_out;
            prev_seg = seg_out;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: first cycle after reset fetches column 0 of slot 0
        #1 check(pix_req && pix_col == 0 && pix_row == 0, "R1 first request",
                 {pix_req, pix_row, pix_col}, {1'b1, 13'd0});
        repeat (NSLOT * 120 * 3 + 50) @(posedge clk);
        @(negedge clk) slot_len = 10'd150;
        repeat (NSLOT * 150 * 3 + 50) @(posedge clk);
        @(negedge clk) slot_len = 10'd40;
        repeat (NSLOT * 120 * 2 + 50) @(posedge clk);
        @(negedge clk) slot_len = 10'd0;
        repeat (NSLOT * 120 * 2 + 50) @(posedge clk);
        @(negedge clk) slot_len = 10'd121;
        repeat (NSLOT * 121 * 2 + 50) @(posedge clk);
        @(negedge clk) done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule